// File: doc/BRIEF.md
# Receive Slot Store with Queued Overwrite Control

This block holds the payloads of received frames for a small set of message slots. An upstream receiver hands over a finished frame with a one-cycle write strobe, a slot index and the payload. For each slot the block keeps an unread flag and an overrun flag. It stores, drops or replaces the frame according to that slot's overwrite enable and whether the slot still holds unread data. Software reads a slot's visible payload through a combinational read port. Software marks the slot as consumed with a clear strobe.

The highest-numbered slot is a two-entry queue. A frame that arrives while its visible entry is unread goes into a hidden holding register. When software clears that slot, the held frame moves into the visible entry by itself. When both entries are full, an overwrite-enabled slot replaces only the held frame. The visible entry is never replaced while it is unread.

Slots whose direction bit marks them as transmit do not take part in reception. Frame writes aimed at them have no effect.

Top module: `rx_slot_store`

## Requirements
- R1: A frame write to an empty receive slot (direction bit 0) stores the payload and sets that slot's unread flag. Both are visible one cycle after the strobe, and the read port then returns the payload for that slot index.
- R2: A frame write to an unread receive slot whose overwrite enable is 0 is dropped. The stored payload, the unread flag and the overrun flag are unchanged.
- R3: A frame write to an unread ordinary receive slot whose overwrite enable is 1 replaces the payload and sets the slot's overrun flag. The overrun flag is only ever set by such a write.
- R4: A frame write to a slot whose direction bit is 1 (transmit) changes neither its payload, its unread flag nor its overrun flag.
- R5: A clear strobe to an ordinary slot with no write in the same cycle clears its unread flag and its overrun flag on the next cycle.
- R6: For the queue slot (index NUM_SLOTS-1), a frame that arrives while the visible entry is unread and the holding register is empty is stored in the holding register. The holding flag goes to 1 and the visible payload is unchanged. The holding flag is never 1 while the queue slot's unread flag is 0.
- R7: A clear strobe to the queue slot while the holding flag is 1 copies the held payload to the visible entry. The unread flag stays 1, the holding flag becomes 0 and the overrun flag clears.
- R8: A frame to the queue slot while both of its entries are unread and its overwrite enable is 0 is dropped. Both entries and the overrun flag are unchanged.
- R9: A frame to the queue slot under the same condition with overwrite enable 1 replaces only the held payload and sets the overrun flag. The visible payload is unchanged.
- R10: When a clear strobe and a frame write hit the same slot in the same cycle, the clear is applied first and the write is then judged against the cleared state.
- R11: A synchronous active-high reset clears every unread flag, every overrun flag, the holding flag and all stored payloads to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Frame write strobe, one cycle per frame |
| wr_slot | input | $clog2(NUM_SLOTS) | Target slot of the frame write |
| wr_data | input | DATA_W | Frame payload |
| cfg_tx | input | NUM_SLOTS | Per-slot direction bit, 1 = transmit, 0 = receive |
| cfg_ovr_en | input | NUM_SLOTS | Per-slot overwrite enable |
| clr_valid | input | 1 | Software clear strobe |
| clr_slot | input | $clog2(NUM_SLOTS) | Slot to clear |
| rd_slot | input | $clog2(NUM_SLOTS) | Slot selected on the read port |
| rd_data | output | DATA_W | Visible payload of the selected slot |
| fresh | output | NUM_SLOTS | Per-slot unread flag |
| ovr_flag | output | NUM_SLOTS | Per-slot overrun flag |
| hold_valid | output | 1 | Queue slot holding register occupied |

## Verification
Every flag and stored payload is registered. The effect of a write or clear strobe therefore appears exactly one clock edge after the edge that samples the strobe. The read port is combinational, so it follows rd_slot within the same cycle. The bench drives all inputs 1 ns after a rising edge and holds each strobe for exactly one cycle. It samples flags and the read port 1 ns after the next rising edge, so each check falls in the first cycle where the new state is due. Same-cycle clear and write cases are driven in one cycle, so the clear-first ordering is seen in that single update.

// File: rtl/rx_slot_pkg.sv
`timescale 1ns/1ps
package rx_slot_pkg;

    // Outcome of a frame write against one slot
    typedef enum logic [1:0] {
        ACT_DROP    = 2'd0,
        ACT_STORE   = 2'd1,
        ACT_HOLD    = 2'd2,
        ACT_REPLACE = 2'd3
    } slot_act_e;

    // Decide what happens to an incoming frame, given the slot state
    // after any same-cycle clear has been applied.
    function automatic slot_act_e pick_action(
        input logic is_tx,
        input logic has_hold,
        input logic vis_busy,
        input logic hold_busy,
        input logic ovr_en
    );
        if (is_tx)
            return ACT_DROP;
        else if (!vis_busy)
            return ACT_STORE;
        else if (has_hold && !hold_busy)
            return ACT_HOLD;
        else if (ovr_en)
            return ACT_REPLACE;
        else
            return ACT_DROP;
    endfunction

endpackage

// File: rtl/rx_slot_cell.sv
`timescale 1ns/1ps
module rx_slot_cell
    import rx_slot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              is_tx,
    input  logic              ovr_en,
    input  logic              clr_hit,
    output logic              fresh,
    output logic              ovr,
    output logic [DATA_W-1:0] vis_data
);

    logic      vis_busy_c;
    slot_act_e act;

    always_comb begin
        vis_busy_c = fresh & ~clr_hit;
        act        = pick_action(is_tx, 1'b0, vis_busy_c, 1'b0, ovr_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fresh    <= 1'b0;
            ovr      <= 1'b0;
            vis_data <= '0;
        end else begin
            if (clr_hit) begin
                fresh <= 1'b0;
                ovr   <= 1'b0;
            end
            if (wr_hit) begin
                case (act)
                    ACT_STORE: begin
                        vis_data <= wr_data;
                        fresh    <= 1'b1;
                    end
                    ACT_REPLACE: begin
                        vis_data <= wr_data;
                        ovr      <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/rx_queue_cell.sv
`timescale 1ns/1ps
module rx_queue_cell
    import rx_slot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              is_tx,
    input  logic              ovr_en,
    input  logic              clr_hit,
    output logic              fresh,
    output logic              ovr,
    output logic [DATA_W-1:0] vis_data,
    output logic              hold_valid
);

    logic [DATA_W-1:0] hold_data;
    logic              promote;
    logic              vis_busy_c;
    logic              hold_busy_c;
    slot_act_e         act;

    always_comb begin
        promote     = clr_hit & hold_valid;
        vis_busy_c  = promote | (fresh & ~clr_hit);
        hold_busy_c = hold_valid & ~promote;
        act         = pick_action(is_tx, 1'b1, vis_busy_c, hold_busy_c, ovr_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fresh      <= 1'b0;
            ovr        <= 1'b0;
            vis_data   <= '0;
            hold_data  <= '0;
            hold_valid <= 1'b0;
        end else begin
            if (clr_hit) begin
                fresh <= 1'b0;
                ovr   <= 1'b0;
            end
            if (promote) begin
                vis_data   <= hold_data;
                fresh      <= 1'b1;
                hold_valid <= 1'b0;
            end
            if (wr_hit) begin
                case (act)
                    ACT_STORE: begin
                        vis_data <= wr_data;
                        fresh    <= 1'b1;
                    end
                    ACT_HOLD: begin
                        hold_data  <= wr_data;
                        hold_valid <= 1'b1;
                    end
                    ACT_REPLACE: begin
                        hold_data  <= wr_data;
                        hold_valid <= 1'b1;
                        ovr        <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/rx_slot_store.sv
`timescale 1ns/1ps
module rx_slot_store #(
    parameter int NUM_SLOTS = 4,
    parameter int DATA_W    = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_valid,
    input  logic [SLOT_W-1:0]    wr_slot,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [NUM_SLOTS-1:0] cfg_tx,
    input  logic [NUM_SLOTS-1:0] cfg_ovr_en,
    input  logic                 clr_valid,
    input  logic [SLOT_W-1:0]    clr_slot,
    input  logic [SLOT_W-1:0]    rd_slot,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_SLOTS-1:0] fresh,
    output logic [NUM_SLOTS-1:0] ovr_flag,
    output logic                 hold_valid
);

    localparam int QUEUE_SLOT = NUM_SLOTS - 1;

    logic [NUM_SLOTS-1:0] wr_hit;
    logic [NUM_SLOTS-1:0] clr_hit;
    logic [DATA_W-1:0]    vis_data [NUM_SLOTS];

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign wr_hit[i]  = wr_valid  && (wr_slot  == SLOT_W'(i));
        assign clr_hit[i] = clr_valid && (clr_slot == SLOT_W'(i));

        if (i == QUEUE_SLOT) begin : g_queue
            rx_queue_cell #(.DATA_W(DATA_W)) cell_i (
                .clk        (clk),
                .rst        (rst),
                .wr_hit     (wr_hit[i]),
                .wr_data    (wr_data),
                .is_tx      (cfg_tx[i]),
                .ovr_en     (cfg_ovr_en[i]),
                .clr_hit    (clr_hit[i]),
                .fresh      (fresh[i]),
                .ovr        (ovr_flag[i]),
                .vis_data   (vis_data[i]),
                .hold_valid (hold_valid)
            );
        end else begin : g_plain
            rx_slot_cell #(.DATA_W(DATA_W)) cell_i (
                .clk      (clk),
                .rst      (rst),
                .wr_hit   (wr_hit[i]),
                .wr_data  (wr_data),
                .is_tx    (cfg_tx[i]),
                .ovr_en   (cfg_ovr_en[i]),
                .clr_hit  (clr_hit[i]),
                .fresh    (fresh[i]),
                .ovr      (ovr_flag[i]),
                .vis_data (vis_data[i])
            );
        end
    end

    assign rd_data = vis_data[rd_slot];

endmodule

// File: rtl/rx_slot_store_chk.sv
`timescale 1ns/1ps
module rx_slot_store_chk #(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_valid,
    input logic [SLOT_W-1:0]    wr_slot,
    input logic [NUM_SLOTS-1:0] cfg_tx,
    input logic [NUM_SLOTS-1:0] cfg_ovr_en,
    input logic                 clr_valid,
    input logic [SLOT_W-1:0]    clr_slot,
    input logic [NUM_SLOTS-1:0] fresh,
    input logic [NUM_SLOTS-1:0] ovr_flag,
    input logic                 hold_valid
);

    localparam int QS = NUM_SLOTS - 1;

    logic [NUM_SLOTS-1:0] w_hit;
    logic [NUM_SLOTS-1:0] c_hit;

    always_comb begin
        for (int k = 0; k < NUM_SLOTS; k++) begin
            w_hit[k] = wr_valid  && (int'(wr_slot)  == k);
            c_hit[k] = clr_valid && (int'(clr_slot) == k);
        end
    end

    // R11
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (fresh == '0 && ovr_flag == '0 && !hold_valid));

    // R6
    hold_needs_fresh_chk: assert property (@(posedge clk) disable iff (rst)
        hold_valid |-> fresh[QS]);

    // R7
    promote_chk: assert property (@(posedge clk) disable iff (rst)
        (c_hit[QS] && hold_valid && !w_hit[QS]) |=> (fresh[QS] && !hold_valid && !ovr_flag[QS]));

    // R8
    queue_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (w_hit[QS] && !c_hit[QS] && fresh[QS] && hold_valid && !cfg_ovr_en[QS] && !cfg_tx[QS])
        |=> (hold_valid && fresh[QS] && $stable(ovr_flag[QS])));

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
        // R4
        tx_ignore_chk: assert property (@(posedge clk) disable iff (rst)
            (w_hit[i] && cfg_tx[i] && !c_hit[i]) |=> ($stable(fresh[i]) && $stable(ovr_flag[i])));

        // R1
        store_sets_fresh_chk: assert property (@(posedge clk) disable iff (rst)
            (w_hit[i] && !cfg_tx[i]) |=> fresh[i]);

        // R3
        ovr_source_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(ovr_flag[i]) |-> $past(w_hit[i] && cfg_ovr_en[i] && !cfg_tx[i]));

        if (i != QS) begin : g_plain_clr
            // R5
            clear_chk: assert property (@(posedge clk) disable iff (rst)
                (c_hit[i] && !w_hit[i]) |=> (!fresh[i] && !ovr_flag[i]));
        end
    end

endmodule

bind rx_slot_store rx_slot_store_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (wr_valid),
    .wr_slot    (wr_slot),
    .cfg_tx     (cfg_tx),
    .cfg_ovr_en (cfg_ovr_en),
    .clr_valid  (clr_valid),
    .clr_slot   (clr_slot),
    .fresh      (fresh),
    .ovr_flag   (ovr_flag),
    .hold_valid (hold_valid)
);

// File: tb/rx_slot_store_tb_top.sv
`timescale 1ns/1ps
module rx_slot_store_tb_top;

    localparam int N  = 4;
    localparam int DW = 32;
    localparam int SW = $clog2(N);
    localparam int QS = N - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [SW-1:0] wr_slot = '0;
    logic [DW-1:0] wr_data = '0;
    logic [N-1:0]  cfg_tx = '0;
    logic [N-1:0]  cfg_ovr_en = '0;
    logic          clr_valid = 1'b0;
    logic [SW-1:0] clr_slot = '0;
    logic [SW-1:0] rd_slot = '0;
    logic [DW-1:0] rd_data;
    logic [N-1:0]  fresh;
    logic [N-1:0]  ovr_flag;
    logic          hold_valid;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    rx_slot_store #(.NUM_SLOTS(N), .DATA_W(DW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (wr_valid),
        .wr_slot    (wr_slot),
        .wr_data    (wr_data),
        .cfg_tx     (cfg_tx),
        .cfg_ovr_en (cfg_ovr_en),
        .clr_valid  (clr_valid),
        .clr_slot   (clr_slot),
        .rd_slot    (rd_slot),
        .rd_data    (rd_data),
        .fresh      (fresh),
        .ovr_flag   (ovr_flag),
        .hold_valid (hold_valid)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic peek(input int slot, output logic [DW-1:0] val);
        rd_slot = SW'(slot);
        #0.5;
        val = rd_data;
    endtask

    task automatic write_frame(input int slot, input logic [DW-1:0] d);
        wr_valid = 1'b1; wr_slot = SW'(slot); wr_data = d;
        step();
        wr_valid = 1'b0;
    endtask

    task automatic clear_slot(input int slot);
        clr_valid = 1'b1; clr_slot = SW'(slot);
        step();
        clr_valid = 1'b0;
    endtask

    task automatic clear_and_write(input int slot, input logic [DW-1:0] d);
        clr_valid = 1'b1; clr_slot = SW'(slot);
        wr_valid = 1'b1; wr_slot = SW'(slot); wr_data = d;
        step();
        clr_valid = 1'b0; wr_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        chk("R11 fresh", DW'(fresh), 0);
        chk("R11 ovr", DW'(ovr_flag), 0);
        chk("R11 hold_valid", DW'(hold_valid), 0);
        peek(0, v);
        chk("R11 data slot0", v, 0);
    endtask

    task automatic t_plain_slot();
        logic [DW-1:0] v;
        write_frame(0, 32'hA0A0_0001);
        chk("R1 fresh set", DW'(fresh[0]), 1);
        peek(0, v);
        chk("R1 stored payload", v, 32'hA0A0_0001);
        cfg_ovr_en[0] = 1'b0;
        write_frame(0, 32'hB0B0_0002);
        peek(0, v);
        chk("R2 payload kept", v, 32'hA0A0_0001);
        chk("R2 no overrun", DW'(ovr_flag[0]), 0);
        chk("R2 fresh kept", DW'(fresh[0]), 1);
        cfg_ovr_en[0] = 1'b1;
        write_frame(0, 32'hC0C0_0003);
        peek(0, v);
        chk("R3 payload replaced", v, 32'hC0C0_0003);
        chk("R3 overrun set", DW'(ovr_flag[0]), 1);
        clear_slot(0);
        chk("R5 fresh cleared", DW'(fresh[0]), 0);
        chk("R5 overrun cleared", DW'(ovr_flag[0]), 0);
        cfg_ovr_en[0] = 1'b0;
    endtask

    task automatic t_tx_slot();
        logic [DW-1:0] v;
        cfg_tx[1] = 1'b1;
        cfg_ovr_en[1] = 1'b1;
        write_frame(1, 32'hD0D0_0004);
        chk("R4 fresh unchanged", DW'(fresh[1]), 0);
        chk("R4 overrun unchanged", DW'(ovr_flag[1]), 0);
        peek(1, v);
        chk("R4 payload unchanged", v, 0);
        cfg_tx[1] = 1'b0;
        cfg_ovr_en[1] = 1'b0;
    endtask

    task automatic t_plain_same_cycle();
        logic [DW-1:0] v;
        write_frame(2, 32'h0000_0011);
        clear_and_write(2, 32'h0000_0022);
        peek(2, v);
        chk("R10 plain new payload", v, 32'h0000_0022);
        chk("R10 plain fresh", DW'(fresh[2]), 1);
        chk("R10 plain no overrun", DW'(ovr_flag[2]), 0);
        clear_slot(2);
    endtask

    task automatic t_queue_drop();
        logic [DW-1:0] v;
        cfg_ovr_en[QS] = 1'b0;
        write_frame(QS, 32'h0000_0031);
        chk("R1 queue fresh", DW'(fresh[QS]), 1);
        chk("R6 hold empty", DW'(hold_valid), 0);
        write_frame(QS, 32'h0000_0032);
        chk("R6 hold filled", DW'(hold_valid), 1);
        peek(QS, v);
        chk("R6 visible kept", v, 32'h0000_0031);
        write_frame(QS, 32'h0000_0033);
        peek(QS, v);
        chk("R8 visible kept", v, 32'h0000_0031);
        chk("R8 no overrun", DW'(ovr_flag[QS]), 0);
        chk("R8 hold still full", DW'(hold_valid), 1);
        clear_slot(QS);
        peek(QS, v);
        chk("R7/R8 promoted held payload", v, 32'h0000_0032);
        chk("R7 fresh after promote", DW'(fresh[QS]), 1);
        chk("R7 hold emptied", DW'(hold_valid), 0);
        clear_slot(QS);
        chk("R5 queue cleared", DW'(fresh[QS]), 0);
    endtask

    task automatic t_queue_replace();
        logic [DW-1:0] v;
        cfg_ovr_en[QS] = 1'b0;
        write_frame(QS, 32'h0000_0041);
        write_frame(QS, 32'h0000_0042);
        cfg_ovr_en[QS] = 1'b1;
        write_frame(QS, 32'h0000_0043);
        chk("R9 overrun set", DW'(ovr_flag[QS]), 1);
        peek(QS, v);
        chk("R9 visible untouched", v, 32'h0000_0041);
        clear_slot(QS);
        peek(QS, v);
        chk("R9 held replaced", v, 32'h0000_0043);
        chk("R7 overrun cleared", DW'(ovr_flag[QS]), 0);
        chk("R7 hold emptied", DW'(hold_valid), 0);
        clear_slot(QS);
        cfg_ovr_en[QS] = 1'b0;
    endtask

    task automatic t_queue_same_cycle();
        logic [DW-1:0] v;
        write_frame(QS, 32'h0000_0051);
        write_frame(QS, 32'h0000_0052);
        clear_and_write(QS, 32'h0000_0053);
        peek(QS, v);
        chk("R10 queue promoted", v, 32'h0000_0052);
        chk("R10 queue new frame held", DW'(hold_valid), 1);
        chk("R10 queue fresh", DW'(fresh[QS]), 1);
        chk("R10 queue no overrun", DW'(ovr_flag[QS]), 0);
        clear_slot(QS);
        peek(QS, v);
        chk("R10 queue second promote", v, 32'h0000_0053);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_plain_slot();
        t_tx_slot();
        t_plain_same_cycle();
        t_queue_drop();
        t_queue_replace();
        t_queue_same_cycle();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule